// File: doc/BRIEF.md
# Dual-Timing Synchronous FIFO

This block is a one-direction, 36-bit FIFO. Its write side and its read side run on separate clocks. The two clocks may be unrelated or may be the same clock. The block has two timing modes, and the mode level is taken from an input while master reset is held.

In standard mode the read side shows an empty flag. A word moves onto the output bus only in the read clock edge that follows a read request. The write side shows a full flag.

In fall-through mode the read side shows an output-ready flag. The oldest stored word is placed on the output bus without any request, and a read consumes that word. The write side shows an input-ready flag. In this mode the output register adds one storage place.

Master reset empties the FIFO and loads the mode. Partial reset empties the FIFO but keeps the mode that was loaded.

Top module: `dtf_fifo`

## Requirements
- R1: The timing mode is loaded from `modeSel` only at read and write clock edges while `mrstN` is low. A value of 1 selects standard mode and 0 selects fall-through mode. Changes on `modeSel` at any other time, including during partial reset, have no effect.
- R2: In standard mode, `rdFlag` is 1 exactly when the FIFO holds no word, and `wrFlag` is 1 exactly when it holds 2^AW words (16 by default). After reset these flags read 1 and 0, and `rdData` reads 0.
- R3: In fall-through mode, `rdFlag` is 1 exactly when a valid word is present on `rdData`, and `wrFlag` is 1 exactly when a write would be accepted. After reset these flags read 0 and 1.
- R4: A transfer happens on a rising edge of its clock only while the chip-select input of that side is 0 and its enable input is 1.
- R5: `rdDataOe` is 1 exactly when `rdCsN` is 0. It models the output bus being driven instead of floating.
- R6: In standard mode, an accepted read places the oldest word on `rdData` at that read clock edge. Without an accepted read, `rdData` keeps its value.
- R7: In fall-through mode, the oldest word appears on `rdData` with `rdFlag` at 1 and no read request. An accepted read moves the next word forward. Without an accepted read, the word and the flag are held.
- R8: A write attempted while the FIFO has no space is ignored. No stored word is overwritten, and the write pointer is not advanced. The capacity is 2^AW words in standard mode and 2^AW+1 words in fall-through mode.
- R9: A read attempted while `rdFlag` shows no data is ignored. `rdData` is unchanged, and later words still come out correctly.
- R10: Asserting either `mrstN` or `prstN` (both are active low) empties the FIFO, and no word written before the reset is ever read. Partial reset keeps the loaded mode.
- R11: Words are read out in the order they were written, with nothing lost or duplicated, when the two clocks are asynchronous.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write clock |
| rdClk | input | 1 | Read clock |
| mrstN | input | 1 | Master reset, active low: empties the FIFO and loads the mode |
| prstN | input | 1 | Partial reset, active low: empties the FIFO and keeps the mode |
| modeSel | input | 1 | Timing mode level, 1 standard, 0 fall-through |
| wrCsN | input | 1 | Write chip select, active low |
| wrEn | input | 1 | Write enable |
| wrData | input | 36 | Write data |
| wrFlag | output | 1 | Full (standard mode) or input-ready (fall-through mode) |
| rdCsN | input | 1 | Read chip select, active low |
| rdEn | input | 1 | Read enable |
| rdData | output | 36 | Read data |
| rdDataOe | output | 1 | Output bus enable |
| rdFlag | output | 1 | Empty (standard mode) or output-ready (fall-through mode) |

## Verification
The bench fills the FIFO to capacity in both modes and then forces writes past the flag. A design that let such a write through would either overwrite the oldest word or return an extra word after the drain. It also pulses reads while the FIFO is empty. A design that moved its read pointer there would return stale data and fall out of step with the scoreboard.

Fall-through mode is checked for a word that shows up with no request. A design that waited for a read would never raise `rdFlag`. Partial reset is applied while the mode input carries the opposite level. A design that reloaded its mode then would invert the sense of both flags. Streaming runs with unrelated clocks expose pointer-crossing errors as reordered or lost words.

// File: rtl/dtf_pkg.sv
package dtf_pkg;
  // Strobes and mode copies passed from control to datapath.
  typedef struct packed {
    logic memWr;   // store wrData this write edge
    logic rdLoad;  // load the output register this read edge
    logic wrStd;   // write-domain mode copy, 1 = standard
    logic rdStd;   // read-domain mode copy, 1 = standard
  } strobe_t;
endpackage

// File: rtl/dtf_ctrl.sv
module dtf_ctrl #(
  parameter int AW = 4
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              mrstN,
  input  logic              prstN,
  input  logic              modeSel,
  input  logic              wrCsN,
  input  logic              wrEn,
  input  logic              rdCsN,
  input  logic              rdEn,
  output dtf_pkg::strobe_t  strb,
  output logic [AW-1:0]     wrAddr,
  output logic [AW-1:0]     rdAddr,
  output logic              wrFlag,
  output logic              rdFlag
);
  localparam int PW = AW + 1;

  function automatic logic [PW-1:0] toGray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  logic rstN;
  assign rstN = mrstN & prstN;

  // Mode is loaded only while master reset is held, one copy per domain.
  logic wrStd, rdStd;
  always_ff @(posedge wrClk) if (!mrstN) wrStd <= modeSel;
  always_ff @(posedge rdClk) if (!mrstN) rdStd <= modeSel;

  logic [PW-1:0] wBin, wGray, rBin, rGray;
  logic [PW-1:0] rGrayS1, rGrayS2, wGrayS1, wGrayS2;

  // Write domain
  logic full, wrGo;
  assign full = (wGray == {~rGrayS2[PW-1:PW-2], rGrayS2[PW-3:0]});
  assign wrGo = !wrCsN && wrEn && !full;

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) begin
      wBin    <= '0;
      wGray   <= '0;
      rGrayS1 <= '0;
      rGrayS2 <= '0;
    end else begin
      rGrayS1 <= rGray;
      rGrayS2 <= rGrayS1;
      if (wrGo) begin
        wBin  <= wBin + 1'b1;
        wGray <= toGray(wBin + 1'b1);
      end
    end
  end

  // Read domain
  logic memEmpty, rdTake, rdLoad, outValid;
  assign memEmpty = (rGray == wGrayS2);
  assign rdTake   = !rdCsN && rdEn;
  assign rdLoad   = rdStd ? (rdTake && !memEmpty)
                          : (!memEmpty && (!outValid || rdTake));

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) begin
      rBin     <= '0;
      rGray    <= '0;
      wGrayS1  <= '0;
      wGrayS2  <= '0;
      outValid <= 1'b0;
    end else begin
      wGrayS1 <= wGray;
      wGrayS2 <= wGrayS1;
      if (rdLoad) begin
        rBin  <= rBin + 1'b1;
        rGray <= toGray(rBin + 1'b1);
      end
      if (!rdStd) begin
        if (rdLoad)      outValid <= 1'b1;
        else if (rdTake) outValid <= 1'b0;
      end
    end
  end

  assign wrFlag = wrStd ? full : !full;
  assign rdFlag = rdStd ? memEmpty : outValid;
  assign wrAddr = wBin[AW-1:0];
  assign rdAddr = rBin[AW-1:0];

  always_comb begin
    strb        = '0;
    strb.memWr  = wrGo;
    strb.rdLoad = rdLoad;
    strb.wrStd  = wrStd;
    strb.rdStd  = rdStd;
  end
endmodule

// File: rtl/dtf_data.sv
module dtf_data #(
  parameter int DW = 36,
  parameter int AW = 4
) (
  input  logic              wrClk,
  input  logic              rdClk,
  input  logic              rstN,
  input  dtf_pkg::strobe_t  strb,
  input  logic [AW-1:0]     wrAddr,
  input  logic [DW-1:0]     wrData,
  input  logic [AW-1:0]     rdAddr,
  output logic [DW-1:0]     rdData
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wrClk) begin
    if (strb.memWr) mem[wrAddr] <= wrData;
  end

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN)            rdData <= '0;
    else if (strb.rdLoad) rdData <= mem[rdAddr];
  end
endmodule

// File: rtl/dtf_fifo.sv
module dtf_fifo #(
  parameter int DW = 36,
  parameter int AW = 4
) (
  input  logic          wrClk,
  input  logic          rdClk,
  input  logic          mrstN,
  input  logic          prstN,
  input  logic          modeSel,
  input  logic          wrCsN,
  input  logic          wrEn,
  input  logic [DW-1:0] wrData,
  output logic          wrFlag,
  input  logic          rdCsN,
  input  logic          rdEn,
  output logic [DW-1:0] rdData,
  output logic          rdDataOe,
  output logic          rdFlag
);
  dtf_pkg::strobe_t strb;
  logic [AW-1:0] wrAddr, rdAddr;
  logic rstN;

  assign rstN     = mrstN & prstN;
  assign rdDataOe = !rdCsN;

  dtf_ctrl #(.AW(AW)) uCtrl (
    .wrClk(wrClk), .rdClk(rdClk), .mrstN(mrstN), .prstN(prstN),
    .modeSel(modeSel), .wrCsN(wrCsN), .wrEn(wrEn), .rdCsN(rdCsN),
    .rdEn(rdEn), .strb(strb), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .wrFlag(wrFlag), .rdFlag(rdFlag)
  );

  dtf_data #(.DW(DW), .AW(AW)) uData (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .strb(strb),
    .wrAddr(wrAddr), .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData)
  );
endmodule

// File: rtl/dtf_fifo_chk.sv
module dtf_fifo_chk #(
  parameter int DW = 36
) (
  input logic             wrClk,
  input logic             rdClk,
  input logic             mrstN,
  input logic             prstN,
  input logic             wrCsN,
  input logic             wrEn,
  input logic             wrFlag,
  input logic             rdCsN,
  input logic             rdEn,
  input logic             rdFlag,
  input logic [DW-1:0]    rdData,
  input dtf_pkg::strobe_t strb
);
  p_write_gate_r4: assert property (@(posedge wrClk) disable iff (!mrstN || !prstN)
    strb.memWr |-> (!wrCsN && wrEn));

  p_no_overflow_r8: assert property (@(posedge wrClk) disable iff (!mrstN || !prstN)
    strb.memWr |-> (strb.wrStd ? !wrFlag : wrFlag));

  p_std_read_r6: assert property (@(posedge rdClk) disable iff (!mrstN || !prstN)
    (strb.rdStd && strb.rdLoad) |-> (!rdFlag && !rdCsN && rdEn));

  p_std_hold_r9: assert property (@(posedge rdClk) disable iff (!mrstN || !prstN)
    (strb.rdStd && !strb.rdLoad) |=> $stable(rdData));

  p_fwft_hold_r7: assert property (@(posedge rdClk) disable iff (!mrstN || !prstN)
    (!strb.rdStd && rdFlag && !(!rdCsN && rdEn)) |=> (rdFlag && $stable(rdData)));
endmodule

bind dtf_fifo dtf_fifo_chk #(.DW(DW)) uChk (
  .wrClk(wrClk), .rdClk(rdClk), .mrstN(mrstN), .prstN(prstN),
  .wrCsN(wrCsN), .wrEn(wrEn), .wrFlag(wrFlag), .rdCsN(rdCsN),
  .rdEn(rdEn), .rdFlag(rdFlag), .rdData(rdData), .strb(strb)
);

// File: tb/sim_dtf_fifo.sv
`timescale 1ns/1ps
module sim_dtf_fifo;
  localparam int DW = 36;
  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;

  logic wrClk = 0, rdClk = 0;
  logic mrstN = 0, prstN = 1, modeSel = 1;
  logic wrCsN = 1, wrEn = 0, rdCsN = 0, rdEn = 0;
  logic [DW-1:0] wrData = '0;
  logic [DW-1:0] rdData;
  logic wrFlag, rdFlag, rdDataOe;

  always #2.5 wrClk = ~wrClk;   // 200 MHz write clock
  always #3.5 rdClk = ~rdClk;   // unrelated read clock

  dtf_fifo #(.DW(DW), .AW(AW)) u0 (
    .wrClk(wrClk), .rdClk(rdClk), .mrstN(mrstN), .prstN(prstN),
    .modeSel(modeSel), .wrCsN(wrCsN), .wrEn(wrEn), .wrData(wrData),
    .wrFlag(wrFlag), .rdCsN(rdCsN), .rdEn(rdEn), .rdData(rdData),
    .rdDataOe(rdDataOe), .rdFlag(rdFlag)
  );

  int nChk = 0, nFail = 0;
  bit curStd = 1;
  bit done = 0;
  logic [DW-1:0] sb[$];

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] mk(input int i, input logic [31:0] salt);
    logic [31:0] v = 32'(i) * 32'h9E3779B1;
    return {4'(i), v ^ salt};
  endfunction

  task automatic masterReset(input bit std);
    @(negedge wrClk);
    mrstN = 0; modeSel = std;
    #40;
    @(negedge wrClk);
    mrstN = 1;
    curStd = std;
    sb.delete();
    repeat (3) @(negedge rdClk);
  endtask

  task automatic pushWord(input logic [DW-1:0] d);
    @(negedge wrClk);
    while (curStd ? wrFlag : !wrFlag) @(negedge wrClk);
    wrCsN = 0; wrEn = 1; wrData = d;
    @(negedge wrClk);
    wrCsN = 1; wrEn = 0;
    sb.push_back(d);
  endtask

  task automatic popWords(input int n, input string req);
    int got = 0;
    logic [DW-1:0] exp;
    while (got < n) begin
      @(negedge rdClk);
      if (curStd) begin
        if (!rdFlag) begin
          rdEn = 1;
          @(negedge rdClk);
          rdEn = 0;
          exp = sb.pop_front();
          check(rdData == exp, req, rdData, exp);
          got++;
        end
      end else if (rdFlag) begin
        exp = sb.pop_front();
        check(rdData == exp, req, rdData, exp);
        rdEn = 1;
        @(negedge rdClk);
        rdEn = 0;
        got++;
      end
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  endtask

  initial begin
    #500000;
    nChk++; nFail++;
    $display("FAIL watchdog expired actual=%h expected=%h", 1'b1, 1'b0);
    finishRun();
  end

  initial begin
    // ---------------- standard mode ----------------
    masterReset(1);
    check(rdFlag == 1'b1, "R2 reset empty", DW'(rdFlag), 1);
    check(wrFlag == 1'b0, "R2 reset not full", DW'(wrFlag), 0);
    check(rdData == '0, "R2 reset data", rdData, 0);

    // R5 output enable follows read chip select
    @(negedge rdClk); rdCsN = 1; #1;
    check(rdDataOe == 1'b0, "R5 oe off", DW'(rdDataOe), 0);
    rdCsN = 0; #1;
    check(rdDataOe == 1'b1, "R5 oe on", DW'(rdDataOe), 1);

    // R4 writes without chip select or without enable are not stored
    @(negedge wrClk); wrCsN = 1; wrEn = 1; wrData = 36'h111111111;
    repeat (3) @(negedge wrClk);
    wrCsN = 0; wrEn = 0;
    repeat (3) @(negedge wrClk);
    wrCsN = 1;
    repeat (6) @(negedge rdClk);
    check(rdFlag == 1'b1, "R4 gated write stored nothing", DW'(rdFlag), 1);

    // R9 reads on empty are ignored, data held
    @(negedge rdClk); rdEn = 1;
    repeat (3) @(negedge rdClk);
    rdEn = 0;
    check(rdData == '0, "R9 empty read holds data", rdData, 0);
    pushWord(36'h0CAFE0001);
    popWords(1, "R9 pointer intact after empty reads");

    // R11/R6 streaming with asynchronous clocks
    fork
      for (int i = 0; i < 40; i++) pushWord(mk(i, 32'h5A5A0000));
      popWords(40, "R11 std stream order");
    join

    // R8/R2 fill to capacity, force writes, drain
    for (int i = 0; i < DEPTH; i++) pushWord(mk(i, 32'h0F0F0F0F));
    repeat (2) @(negedge wrClk);
    check(wrFlag == 1'b1, "R2 full flag at capacity", DW'(wrFlag), 1);
    wrCsN = 0; wrEn = 1; wrData = 36'hBADBADBAD;
    repeat (3) @(negedge wrClk);
    wrCsN = 1; wrEn = 0;
    popWords(DEPTH, "R8 no overwrite when full");
    repeat (8) @(negedge rdClk);
    check(rdFlag == 1'b1, "R8 extra write absent", DW'(rdFlag), 1);

    // R10 partial reset empties, keeps standard mode despite modeSel=0
    for (int i = 0; i < 3; i++) pushWord(mk(i, 32'h12340000));
    repeat (6) @(negedge rdClk);
    check(rdFlag == 1'b0, "R10 data present before partial reset", DW'(rdFlag), 0);
    @(negedge wrClk); modeSel = 0; prstN = 0;
    #30;
    @(negedge wrClk); prstN = 1;
    sb.delete();
    repeat (6) @(negedge rdClk);
    check(rdFlag == 1'b1, "R10 empty after partial reset, R1 mode kept", DW'(rdFlag), 1);
    check(wrFlag == 1'b0, "R10 not full after partial reset", DW'(wrFlag), 0);
    modeSel = 1;
    pushWord(36'h0ABCDEF01);
    popWords(1, "R10 first word after partial reset");

    // ---------------- fall-through mode ----------------
    masterReset(0);
    modeSel = 1;   // R1: change outside master reset must be ignored
    repeat (4) @(negedge wrClk);
    check(rdFlag == 1'b0, "R3 reset not ready, R1 mode held", DW'(rdFlag), 0);
    check(wrFlag == 1'b1, "R3 reset input ready", DW'(wrFlag), 1);

    // R9 reads while not ready are ignored
    @(negedge rdClk); rdEn = 1;
    repeat (3) @(negedge rdClk);
    rdEn = 0;
    check(rdFlag == 1'b0, "R9 fwft read on empty", DW'(rdFlag), 0);

    // R7 first word falls through without a read
    pushWord(36'h0FEED0042);
    repeat (6) @(negedge rdClk);
    check(rdFlag == 1'b1, "R7 ready without request", DW'(rdFlag), 1);
    check(rdData == 36'h0FEED0042, "R7 word on bus", rdData, 36'h0FEED0042);
    popWords(1, "R7 consume");
    repeat (2) @(negedge rdClk);
    check(rdFlag == 1'b0, "R7 not ready after last word", DW'(rdFlag), 0);

    // R11 fall-through streaming
    fork
      for (int i = 0; i < 40; i++) pushWord(mk(i, 32'hC3C30000));
      popWords(40, "R11 fwft stream order");
    join

    // R8 capacity DEPTH+1 in fall-through mode
    for (int i = 0; i < DEPTH + 1; i++) pushWord(mk(i, 32'h77770000));
    repeat (8) @(negedge wrClk);
    check(wrFlag == 1'b0, "R8 fwft no space at capacity", DW'(wrFlag), 0);
    wrCsN = 0; wrEn = 1; wrData = 36'hBADBADBAD;
    repeat (3) @(negedge wrClk);
    wrCsN = 1; wrEn = 0;
    popWords(DEPTH + 1, "R8 fwft no overwrite");
    repeat (8) @(negedge rdClk);
    check(rdFlag == 1'b0, "R8 fwft extra write absent", DW'(rdFlag), 0);

    finishRun();
  end
endmodule